// File: doc/BRIEF.md
# Fractional-N Clock Divider

This block derives a slow clock from a fast one with no analog help. The ratio can be a non-integer number that a fixed integer divide cannot reach. Each output period is counted out in input clocks and lasts either a base count N or N+1. A small modular accumulator adds a fixed numerator once per period. Each time it overflows, the next period becomes the longer one. With the default settings (N = 488, numerator 9, denominator 2^5 = 32) the average ratio is 488 + 9/32 = 488.28125. For a 125 MHz input this gives exactly 256 kHz. The fractional step is held as an exact integer numerator over the accumulator modulus, so the average never drifts.

The output is high for the first half (rounded down) of each period and low for the rest. A one-cycle pulse marks the last input cycle of every period. An enable input freezes the whole divider: the count, the accumulator and the output level all hold while it is low. The reset is synchronous.

Top module: `fracn_clk_div`

## Requirements
- R1: While reset is high, and in the cycle after any clock edge at which reset was high, `clk_out` and `period_tick` are both 0.
- R2: Every output period, measured between successive `period_tick` pulses with enable held high, lasts either 488 or 489 input clocks, so the edge jitter never exceeds one input period.
- R3: Periods are numbered from 0 after reset. Period 0 lasts 488 clocks. Period p (p ≥ 1) lasts 489 clocks exactly when floor(9p/32) > floor(9(p−1)/32), and 488 otherwise. For example, periods 4, 8, 11, 15 and 32 are long and periods 1, 5 and 31 are short.
- R4: Any 32 consecutive periods that do not include period 0 contain exactly 9 long periods and total exactly 15625 input clocks.
- R5: Within each period, `clk_out` is high for exactly floor(length/2) = 244 enabled input clocks, beginning at the period's first clock, and low for the remaining 244 or 245.
- R6: `period_tick` is high for exactly one cycle per period, in the last low cycle of `clk_out`. When enable is high in that cycle, `clk_out` is 1 in the following cycle.
- R7: While `en` is low, `clk_out` holds its value, `period_tick` stays 0, and the position within the period and the accumulator state are frozen. Each disabled clock lengthens the current period by one clock, and the period sequence continues unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the divider |
| clk_out | output | 1 | Divided clock, high during the first half of each period |
| period_tick | output | 1 | One-cycle pulse in the last input cycle of each period |

## Verification
The checker watches these properties on every cycle:
- the output is quiet after reset;
- each tick is one cycle wide and followed by a rising output;
- output and tick are frozen while enable is low;
- every period length between wraps stays within one clock of the base ratio;
- the first period is short;
- every aligned group of 32 periods holds exactly the numerator's count of long periods.

Only the bench's scenarios can show the following, because they need a reference ordering or an absolute clock count:
- which particular periods are long;
- the exact 15625-clock total over a shifted window;
- the exact high time;
- how a pause stretches one period by exactly the number of disabled cycles.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

  typedef enum logic {
    LEVEL_LOW  = 1'b0,
    LEVEL_HIGH = 1'b1
  } level_e;

  // Length in input clocks of a period, given the base ratio and the long flag.
  function automatic int unsigned period_len(int unsigned base, logic long_sel);
    return base + 32'(long_sel);
  endfunction

  // Number of high clocks in a period of the given length (rounded down half).
  function automatic int unsigned high_len(int unsigned len);
    return len >> 1;
  endfunction

  // Index of the last count value in a period of the given length.
  function automatic int unsigned last_count(int unsigned len);
    return len - 1;
  endfunction

endpackage

// File: rtl/fracn_frac_accum.sv
module fracn_frac_accum #(
  parameter int FRAC_NUM = 9,
  parameter int FRAC_EXP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic long_q
);
  localparam int SW = FRAC_EXP + 1;
  localparam logic [SW-1:0] STEP_V = SW'(FRAC_NUM);

  logic [FRAC_EXP-1:0] acc_q;
  logic [SW-1:0]       sum;

  always_comb begin
    sum = {1'b0, acc_q} + STEP_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      long_q <= 1'b0;
    end else if (step) begin
      acc_q  <= sum[FRAC_EXP-1:0];
      long_q <= sum[FRAC_EXP];
    end
  end
endmodule

// File: rtl/fracn_period_cnt.sv
module fracn_period_cnt #(
  parameter int INT_DIV = 488,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          long_sel,
  output logic [CW-1:0] cnt_q,
  output logic          wrap
);
  import fracn_div_pkg::*;

  logic          at_last;
  logic [CW-1:0] last_v;

  always_comb begin
    last_v  = CW'(last_count(period_len(INT_DIV, long_sel)));
    at_last = (cnt_q == last_v);
    wrap    = en & at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fracn_wave_gen.sv
module fracn_wave_gen #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] half,
  input  logic          wrap,
  output logic          clk_q,
  output logic          tick_q
);
  import fracn_div_pkg::*;

  level_e lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LEVEL_LOW;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (en) begin
        lvl_q <= (cnt < half) ? LEVEL_HIGH : LEVEL_LOW;
      end
    end
  end

  assign clk_q = (lvl_q == LEVEL_HIGH);
endmodule

// File: rtl/fracn_clk_div.sv
module fracn_clk_div #(
  parameter int INT_DIV  = 488,
  parameter int FRAC_NUM = 9,
  parameter int FRAC_EXP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_out,
  output logic period_tick
);
  import fracn_div_pkg::*;

  localparam int CW = $clog2(INT_DIV + 2);

  // Named internal events, visible to the bound checker.
  logic          period_wrap;
  logic          long_period;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_v;

  always_comb begin
    half_v = CW'(high_len(period_len(INT_DIV, long_period)));
  end

  fracn_frac_accum #(
    .FRAC_NUM(FRAC_NUM),
    .FRAC_EXP(FRAC_EXP)
  ) u_accum (
    .clk   (clk),
    .rst   (rst),
    .step  (period_wrap),
    .long_q(long_period)
  );

  fracn_period_cnt #(
    .INT_DIV(INT_DIV),
    .CW     (CW)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .long_sel(long_period),
    .cnt_q   (cnt_q),
    .wrap    (period_wrap)
  );

  fracn_wave_gen #(
    .CW(CW)
  ) u_wave (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .cnt   (cnt_q),
    .half  (half_v),
    .wrap  (period_wrap),
    .clk_q (clk_out),
    .tick_q(period_tick)
  );
endmodule

// File: rtl/fracn_clk_div_chk.sv
module fracn_clk_div_chk #(
  parameter int INT_DIV  = 488,
  parameter int FRAC_NUM = 9,
  parameter int FRAC_EXP = 5
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic clk_out,
  input logic period_tick,
  input logic period_wrap,
  input logic long_period
);
  int unsigned         run_len;
  int unsigned         long_cnt;
  logic [FRAC_EXP-1:0] wrap_idx;
  logic                seen_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len    <= 0;
      long_cnt   <= 0;
      wrap_idx   <= '0;
      seen_first <= 1'b0;
    end else begin
      if (period_wrap) begin
        run_len <= 0;
      end else if (en) begin
        run_len <= run_len + 1;
      end
      if (period_wrap) begin
        seen_first <= 1'b1;
        if (seen_first) begin
          wrap_idx <= wrap_idx + 1'b1;
          if (wrap_idx == '1) begin
            long_cnt <= 0;
          end else begin
            long_cnt <= long_cnt + 32'(long_period);
          end
        end
      end
    end
  end

  // R1: outputs quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!clk_out && !period_tick));

  // R2: period length stays within one clock of the base ratio
  a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
    period_wrap |-> (run_len >= INT_DIV - 1 && run_len <= INT_DIV));

  // R3: first period after reset is the short one
  a_r3_first_short: assert property (@(posedge clk) disable iff (rst)
    (period_wrap && !seen_first) |-> !long_period);

  // R4: each aligned group of 2^FRAC_EXP periods after the first has FRAC_NUM long ones
  a_r4_long_count: assert property (@(posedge clk) disable iff (rst)
    (period_wrap && seen_first && wrap_idx == '1) |-> (long_cnt + 32'(long_period) == FRAC_NUM));

  // R6: tick is a single cycle
  a_r6_tick_single: assert property (@(posedge clk) disable iff (rst)
    period_tick |=> !period_tick);

  // R6: output rises right after an enabled tick cycle
  a_r6_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
    (period_tick && en) |=> clk_out);

  // R7: disabled clocks freeze the output
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(clk_out) && !period_tick));
endmodule

bind fracn_clk_div fracn_clk_div_chk #(
  .INT_DIV (INT_DIV),
  .FRAC_NUM(FRAC_NUM),
  .FRAC_EXP(FRAC_EXP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .clk_out    (clk_out),
  .period_tick(period_tick),
  .period_wrap(period_wrap),
  .long_period(long_period)
);

// File: tb/fracn_clk_div_test.sv
module fracn_clk_div_test;
  localparam int BASE  = 488;
  localparam int NUM   = 9;
  localparam int DEN   = 32;
  localparam int MAXP  = 64;
  localparam int NTAB  = 8;
  // Table of {period index, expected length} taken from R3.
  localparam int TBL [NTAB][2] = '{
    '{0, 488}, '{1, 488}, '{4, 489}, '{5, 488},
    '{8, 489}, '{11, 489}, '{15, 489}, '{32, 489}
  };

  logic clk = 1'b0;
  logic rst;
  logic en;
  logic clk_out;
  logic period_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Monitor state (written only by the monitor).
  bit mon_on = 1'b0;
  int lens  [MAXP];
  int highs [MAXP];
  int ntick, since, hi, dbl, rise_miss, tick_hi;
  bit prev_tick;

  always #5 clk = ~clk;

  fracn_clk_div uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .clk_out    (clk_out),
    .period_tick(period_tick)
  );

  always @(negedge clk) begin
    if (!mon_on) begin
      ntick = 0; since = 0; hi = 0; dbl = 0; rise_miss = 0; tick_hi = 0;
      prev_tick = 1'b0;
    end else begin
      since = since + 1;
      if (clk_out) hi = hi + 1;
      if (period_tick && prev_tick) dbl = dbl + 1;
      if (prev_tick && !clk_out) rise_miss = rise_miss + 1;
      if (period_tick && clk_out) tick_hi = tick_hi + 1;
      if (period_tick) begin
        if (ntick < MAXP) begin
          lens[ntick]  = since;
          highs[ntick] = hi;
        end
        ntick = ntick + 1;
        since = 0;
        hi    = 0;
      end
      prev_tick = period_tick;
    end
  end

  function automatic int exp_len(int p);
    if (p == 0) return BASE;
    return BASE + (((NUM * p) / DEN) > ((NUM * (p - 1)) / DEN) ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_run();
    mon_on = 1'b0;
    rst = 1'b1;
    en  = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    rst    = 1'b0;
    mon_on = 1'b1;
  endtask

  initial begin
    rst = 1'b1;
    en  = 1'b1;
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    chk(period_tick == 1'b0, "R1 tick in reset", int'(period_tick), 0);

    // Main run: 64 periods with enable held.
    #1;
    rst    = 1'b0;
    mon_on = 1'b1;
    wait (ntick >= MAXP);
    @(negedge clk);

    for (int i = 0; i < NTAB; i++) begin
      chk(lens[TBL[i][0]] == TBL[i][1], "R3 table length", lens[TBL[i][0]], TBL[i][1]);
    end
    for (int p = 0; p < MAXP; p++) begin
      chk(lens[p] == exp_len(p), "R3 length sequence", lens[p], exp_len(p));
      chk(lens[p] == BASE || lens[p] == BASE + 1, "R2 length bound", lens[p], BASE);
      chk(highs[p] == BASE / 2, "R5 high time", highs[p], BASE / 2);
    end
    begin
      int s1 = 0, s2 = 0, nl = 0;
      for (int p = 1; p <= 32; p++) begin
        s1 += lens[p];
        if (lens[p] == BASE + 1) nl++;
      end
      for (int p = 17; p <= 48; p++) s2 += lens[p];
      chk(s1 == 15625, "R4 total periods 1..32", s1, 15625);
      chk(s2 == 15625, "R4 total periods 17..48", s2, 15625);
      chk(nl == 9, "R4 long count", nl, 9);
    end
    chk(dbl == 0, "R6 tick width", dbl, 0);
    chk(rise_miss == 0, "R6 rise after tick", rise_miss, 0);
    chk(tick_hi == 0, "R6 tick in low phase", tick_hi, 0);

    // Enable pause during the high half of period 0.
    start_run();
    repeat (100) @(negedge clk);
    #1;
    en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(clk_out == 1'b1, "R7 level held", int'(clk_out), 1);
      chk(period_tick == 1'b0, "R7 no tick while idle", int'(period_tick), 0);
    end
    #1;
    en = 1'b1;
    wait (ntick >= 2);
    @(negedge clk);
    chk(lens[0] == BASE + 10, "R7 stretched period", lens[0], BASE + 10);
    chk(highs[0] == BASE / 2 + 10, "R7 stretched high", highs[0], BASE / 2 + 10);
    chk(lens[1] == BASE, "R7 sequence resumes", lens[1], BASE);

    // Reset in mid-run while the output is high.
    repeat (50) @(negedge clk);
    chk(clk_out == 1'b1, "R5 high early in period", int'(clk_out), 1);
    #1;
    rst = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b0, "R1 mid-run reset clk_out", int'(clk_out), 0);
    chk(period_tick == 1'b0, "R1 mid-run reset tick", int'(period_tick), 0);

    // Restart after reset: first periods follow R3 from the beginning.
    start_run();
    wait (ntick >= 5);
    @(negedge clk);
    chk(lens[0] == 488, "R3 restart period 0", lens[0], 488);
    chk(lens[4] == 489, "R3 restart period 4", lens[4], 489);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end
endmodule